// File: doc/BRIEF.md
# Remappable Controller Address Decoder

This block sits between the 20-bit address bus of a small 8-bit processor on a graphics board and the memories around it. For every local access it raises exactly one chip select and produces a translated local offset. The targets are firmware ROM, a 16-entry state/parameter register file, a shared communication RAM, video RAM, emulator RAM and the palette lookup-table write port. The register file is held inside the block. Reads of the register file, of the INIT location and of unmapped space take their data from the block itself.

Firmware reads the INIT location once. That read returns zero and sets a sticky remap latch. From then on the top 32 KB window maps to emulator RAM instead of ROM. While the latch is set, writes to a 512-byte slice inside that window go to the palette write port.

The block also decodes the host side of the communication RAM. The host sees a 1 KB window, and a configuration switch picks its base. When both sides want the communication RAM in the same cycle, the local processor goes first.

Top module: `ctl_addr_decode`

## Requirements
- R1: A local access (read or write) to 0x00000–0x0FFFF asserts `sel_rom` with `loc_offset` = address[15:0].
- R2: While `remap_on` is 0, an access to 0xF8000–0xFFFFF asserts `sel_rom` with `loc_offset` = 0x8000 + address[14:0], and this holds for writes as well.
- R3: An access to 0x10000–0x1001F asserts `sel_regs` with `loc_offset` = address[4:1], so odd and even bytes share an entry. A write stores `loc_wdata` at the clock edge. A read returns the entry on `loc_rdata` with `loc_rdata_vld` = 1 in the same cycle.
- R4: An access to 0x28000–0x28FFF asserts `sel_comm` with `loc_offset` = address[10:0]. The upper 2 KB mirrors the lower 2 KB.
- R5: An access to 0x80000–0xF7FFF asserts `sel_vram` with `loc_offset` = address − 0x80000.
- R6: A read of 0x3C000 or 0x3C001 asserts no select and returns 0x00 with `loc_rdata_vld` = 1. `remap_on` is 1 from the next cycle. A write to those addresses leaves `remap_on` unchanged.
- R7: Once `remap_on` is 1 it stays 1 until reset. While it is set, an access to 0xF8000–0xFFFFF asserts `sel_eram` with `loc_offset` = address[14:0].
- R8: While `remap_on` is 1, a write to 0xF8400–0xF85FF asserts `sel_lut` (not `sel_eram`) with `loc_offset` = address[8:0]. Reads there, and writes elsewhere in the window, go to emulator RAM.
- R9: A host request asserts `host_grant` with `host_offset` = host address[9:0] when the host address is in 0xC6000–0xC63FF and `cfg_alt_base` = 0, or in 0xC6400–0xC67FF and `cfg_alt_base` = 1. Any other host address asserts neither `host_grant` nor `host_wait`.
- R10: When a host hit coincides with `sel_comm`, `host_wait` is 1 and `host_grant` is 0. The host is granted in the first cycle without a local communication-RAM access.
- R11: Reset clears all register-file entries to 0x00 and clears `remap_on`.
- R12: At most one select is active. A read of any unmapped address asserts no select and returns 0xFF with `loc_rdata_vld` = 1, with `loc_offset` = 0. With no access, all selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_addr | input | 20 | Local processor address |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 8 | Local write data (register file) |
| host_addr | input | 20 | Host address |
| host_req | input | 1 | Host access request |
| cfg_alt_base | input | 1 | Host window base switch: 0 for 0xC6000, 1 for 0xC6400 |
| sel_rom | output | 1 | Firmware ROM select |
| sel_regs | output | 1 | State/parameter register file select |
| sel_comm | output | 1 | Communication RAM select (local side) |
| sel_vram | output | 1 | Video RAM select |
| sel_eram | output | 1 | Emulator RAM select |
| sel_lut | output | 1 | Palette lookup-table write select |
| loc_offset | output | 19 | Offset inside the selected target |
| loc_rdata | output | 8 | Read data sourced by the block |
| loc_rdata_vld | output | 1 | `loc_rdata` is valid for this read |
| remap_on | output | 1 | Sticky remap latch |
| host_grant | output | 1 | Host access to communication RAM granted |
| host_wait | output | 1 | Host hit held off by a local access |
| host_offset | output | 10 | Offset inside the host window |

## Verification
The hardest state to reach is the remapped top window. Getting there takes an INIT read at an exact address. Checking it means showing that the ROM mapping held before that read and has gone after it. It also means showing that a write to the same INIT address did nothing. The stimulus probes the top window and the palette slice before the INIT read, tries a write to INIT, then reads INIT and probes the same addresses again. A reset pulse after that shows the ROM mapping returning. Host priority is reached by holding one host request across two cycles: the first has a local communication-RAM access and the second does not.

// File: rtl/ctl_addr_decode.sv
module ctl_addr_decode #(
  parameter int NREGS = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [19:0]   loc_addr,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic [19:0]   host_addr,
  input  logic          host_req,
  input  logic          cfg_alt_base,
  output logic          sel_rom,
  output logic          sel_regs,
  output logic          sel_comm,
  output logic          sel_vram,
  output logic          sel_eram,
  output logic          sel_lut,
  output logic [18:0]   loc_offset,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_rdata_vld,
  output logic          remap_on,
  output logic          host_grant,
  output logic          host_wait,
  output logic [9:0]    host_offset
);
  localparam int IW = $clog2(NREGS);
  localparam logic [19:0] REG_BASE = 20'h10000;

  logic [DW-1:0] regs [NREGS];
  logic          acc, in_lo, in_top, in_regs, in_comm, in_vram, in_init, in_lut, none;
  logic [IW-1:0] idx;

  assign acc     = loc_rd | loc_wr;
  assign idx     = loc_addr[IW:1];
  assign in_lo   = loc_addr[19:16] == 4'h0;
  assign in_top  = loc_addr[19:15] == 5'b11111;
  assign in_regs = (loc_addr >> (IW + 1)) == (REG_BASE >> (IW + 1));
  assign in_comm = loc_addr[19:12] == 8'h28;
  assign in_vram = loc_addr[19] & ~in_top;
  assign in_init = loc_addr[19:1] == 19'h1E000;
  assign in_lut  = in_top & (loc_addr[14:9] == 6'd2);

  assign sel_rom  = acc & (in_lo | (in_top & ~remap_on));
  assign sel_regs = acc & in_regs;
  assign sel_comm = acc & in_comm;
  assign sel_vram = acc & in_vram;
  assign sel_lut  = loc_wr & remap_on & in_lut;
  assign sel_eram = acc & remap_on & in_top & ~sel_lut;
  assign none     = ~(sel_rom | sel_regs | sel_comm | sel_vram | sel_eram | sel_lut);

  always_comb begin
    loc_offset = '0;
    if (sel_rom)       loc_offset = in_top ? {3'b0, 1'b1, loc_addr[14:0]} : {3'b0, loc_addr[15:0]};
    else if (sel_regs) loc_offset = 19'(idx);
    else if (sel_comm) loc_offset = {8'b0, loc_addr[10:0]};
    else if (sel_vram) loc_offset = loc_addr[18:0];
    else if (sel_eram) loc_offset = {4'b0, loc_addr[14:0]};
    else if (sel_lut)  loc_offset = {10'b0, loc_addr[8:0]};
  end

  always_comb begin
    loc_rdata_vld = 1'b0;
    loc_rdata     = '1;
    if (loc_rd) begin
      if (sel_regs) begin
        loc_rdata_vld = 1'b1;
        loc_rdata     = regs[idx];
      end else if (in_init) begin
        loc_rdata_vld = 1'b1;
        loc_rdata     = '0;
      end else if (none) begin
        loc_rdata_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_on <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (loc_rd & in_init) remap_on <= 1'b1;
      if (loc_wr & in_regs) regs[idx] <= loc_wdata;
    end
  end

  logic host_hit;
  assign host_hit    = host_req & (host_addr[19:10] == {9'h18C, cfg_alt_base});
  assign host_grant  = host_hit & ~sel_comm;
  assign host_wait   = host_hit & sel_comm;
  assign host_offset = host_addr[9:0];

  a_r12_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_regs, sel_comm, sel_vram, sel_eram, sel_lut}));
  a_r6_init_sets_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rd && in_init) |=> remap_on);
  a_r7_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    remap_on |=> remap_on);
  a_r10_local_first: assert property (@(posedge clk) disable iff (!rst_n)
    sel_comm |-> !host_grant);
  a_r3_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && sel_regs) |=> regs[$past(idx)] == $past(loc_wdata));
  a_r8_lut_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lut |-> (loc_wr && remap_on));
endmodule

// File: tb/sim_ctl_addr_decode.sv
module sim_ctl_addr_decode;
  localparam int PERIOD = 10;

  typedef struct {
    logic [5:0]  sel;
    logic [18:0] off;
    logic        vld;
    logic [7:0]  rd;
    logic        gr;
    logic        wt;
    logic [9:0]  hoff;
    logic        rm;
    string       req;
  } item_t;

  localparam logic [5:0] S_NONE = 6'b000000, S_ROM = 6'b000001, S_REG = 6'b000010,
                         S_COM = 6'b000100, S_VRM = 6'b001000, S_ERM = 6'b010000,
                         S_LUT = 6'b100000;

  logic clk = 0, rst_n = 0;
  logic [19:0] loc_addr = '0, host_addr = '0;
  logic loc_rd = 0, loc_wr = 0, host_req = 0, cfg_alt_base = 0;
  logic [7:0] loc_wdata = '0;
  logic sel_rom, sel_regs, sel_comm, sel_vram, sel_eram, sel_lut;
  logic [18:0] loc_offset;
  logic [7:0] loc_rdata;
  logic loc_rdata_vld, remap_on, host_grant, host_wait;
  logic [9:0] host_offset;

  int checks = 0, errors = 0;
  item_t q[$];
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ctl_addr_decode u0 (
    .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .loc_wdata(loc_wdata), .host_addr(host_addr), .host_req(host_req),
    .cfg_alt_base(cfg_alt_base), .sel_rom(sel_rom), .sel_regs(sel_regs),
    .sel_comm(sel_comm), .sel_vram(sel_vram), .sel_eram(sel_eram), .sel_lut(sel_lut),
    .loc_offset(loc_offset), .loc_rdata(loc_rdata), .loc_rdata_vld(loc_rdata_vld),
    .remap_on(remap_on), .host_grant(host_grant), .host_wait(host_wait),
    .host_offset(host_offset));

  task automatic drv(input logic [19:0] a, input logic r, input logic w, input logic [7:0] wd,
                     input logic [19:0] ha, input logic hr, input logic cf,
                     input logic [5:0] es, input logic [18:0] eo, input logic ev,
                     input logic [7:0] erd, input logic eg, input logic ew,
                     input logic [9:0] eho, input logic erm, input string rq);
    item_t it;
    @(negedge clk);
    loc_addr = a; loc_rd = r; loc_wr = w; loc_wdata = wd;
    host_addr = ha; host_req = hr; cfg_alt_base = cf;
    it.sel = es; it.off = eo; it.vld = ev; it.rd = erd; it.gr = eg; it.wt = ew;
    it.hoff = eho; it.rm = erm; it.req = rq;
    q.push_back(it);
  endtask

  task automatic lr(input logic [19:0] a, input logic [5:0] es, input logic [18:0] eo,
                    input logic ev, input logic [7:0] erd, input logic erm, input string rq);
    drv(a, 1, 0, 8'h00, 20'h0, 0, 0, es, eo, ev, erd, 0, 0, 10'h0, erm, rq);
  endtask

  task automatic lw(input logic [19:0] a, input logic [7:0] wd, input logic [5:0] es,
                    input logic [18:0] eo, input logic erm, input string rq);
    drv(a, 0, 1, wd, 20'h0, 0, 0, es, eo, 0, 8'h00, 0, 0, 10'h0, erm, rq);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        logic [5:0] s;
        bit bad;
        it = q.pop_front();
        s = {sel_lut, sel_eram, sel_vram, sel_comm, sel_regs, sel_rom};
        bad = (s !== it.sel) || (loc_rdata_vld !== it.vld) || (host_grant !== it.gr) ||
              (host_wait !== it.wt) || (remap_on !== it.rm) ||
              (it.sel != 0 && loc_offset !== it.off) || (it.sel == 0 && it.vld && loc_offset !== 19'h0) ||
              (it.vld && loc_rdata !== it.rd) || (it.gr && host_offset !== it.hoff);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: got sel=%b off=%h vld=%b rd=%h gr=%b wt=%b hoff=%h rm=%b exp sel=%b off=%h vld=%b rd=%h gr=%b wt=%b hoff=%h rm=%b",
            it.req, s, loc_offset, loc_rdata_vld, loc_rdata, host_grant, host_wait, host_offset,
            remap_on, it.sel, it.off, it.vld, it.rd, it.gr, it.wt, it.hoff, it.rm);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 / R12 idle after reset
    drv(20'h0, 0, 0, 8'h0, 20'h0, 0, 0, S_NONE, 0, 0, 8'h0, 0, 0, 0, 0, "R11 idle after reset");
    lr(20'h10000, S_REG, 19'd0, 1, 8'h00, 0, "R11 reg cleared");
    // R1
    lr(20'h00000, S_ROM, 19'h00000, 0, 8'h0, 0, "R1 rom low");
    lr(20'h0FFFF, S_ROM, 19'h0FFFF, 0, 8'h0, 0, "R1 rom high");
    // R2
    lr(20'hF8000, S_ROM, 19'h08000, 0, 8'h0, 0, "R2 top window rom");
    lr(20'hFFFFF, S_ROM, 19'h0FFFF, 0, 8'h0, 0, "R2 top window end");
    lw(20'hF8400, 8'h11, S_ROM, 19'h08400, 0, "R2 write before remap");
    // R3
    lw(20'h10004, 8'h5A, S_REG, 19'd2, 0, "R3 write entry 2");
    lr(20'h10005, S_REG, 19'd2, 1, 8'h5A, 0, "R3 odd byte same entry");
    lw(20'h1001F, 8'hC3, S_REG, 19'd15, 0, "R3 write entry 15");
    lr(20'h1001E, S_REG, 19'd15, 1, 8'hC3, 0, "R3 read entry 15");
    // R12
    lr(20'h10020, S_NONE, 0, 1, 8'hFF, 0, "R12 past reg file");
    lr(20'h3C002, S_NONE, 0, 1, 8'hFF, 0, "R12 next to init");
    lr(20'h40000, S_NONE, 0, 1, 8'hFF, 0, "R12 hole");
    // R4
    lr(20'h28000, S_COM, 19'h000, 0, 8'h0, 0, "R4 comm base");
    lr(20'h28FFF, S_COM, 19'h7FF, 0, 8'h0, 0, "R4 mirror end");
    lw(20'h28801, 8'h00, S_COM, 19'h001, 0, "R4 mirror");
    // R5
    lr(20'h80000, S_VRM, 19'h00000, 0, 8'h0, 0, "R5 vram base");
    lr(20'hF7FFF, S_VRM, 19'h77FFF, 0, 8'h0, 0, "R5 vram end");
    // R6
    lw(20'h3C000, 8'hFF, S_NONE, 0, 0, "R6 init write");
    lr(20'hF8000, S_ROM, 19'h08000, 0, 8'h0, 0, "R6 write did not remap");
    lr(20'h3C001, S_NONE, 0, 1, 8'h00, 0, "R6 init read");
    // R7 / R8
    lr(20'hF8000, S_ERM, 19'h0000, 0, 8'h0, 1, "R7 eram base");
    lr(20'hFFFFF, S_ERM, 19'h7FFF, 0, 8'h0, 1, "R7 eram end");
    lw(20'hF8400, 8'h22, S_LUT, 19'h000, 1, "R8 lut low");
    lw(20'hF85FF, 8'h33, S_LUT, 19'h1FF, 1, "R8 lut high");
    lw(20'hF8600, 8'h44, S_ERM, 19'h0600, 1, "R8 past lut");
    lr(20'hF8400, S_ERM, 19'h0400, 0, 8'h0, 1, "R8 read in lut slice");
    lr(20'h0FFFF, S_ROM, 19'h0FFFF, 0, 8'h0, 1, "R7 low rom unchanged");
    lr(20'h10004, S_REG, 19'd2, 1, 8'h5A, 1, "R7 remap sticky");
    // R9
    drv(20'h0, 0, 0, 0, 20'hC6000, 1, 0, S_NONE, 0, 0, 0, 1, 0, 10'h000, 1, "R9 base0 hit");
    drv(20'h0, 0, 0, 0, 20'hC6400, 1, 0, S_NONE, 0, 0, 0, 0, 0, 10'h000, 1, "R9 base0 miss");
    drv(20'h0, 0, 0, 0, 20'hC6400, 1, 1, S_NONE, 0, 0, 0, 1, 0, 10'h000, 1, "R9 base1 hit");
    drv(20'h0, 0, 0, 0, 20'hC67FF, 1, 1, S_NONE, 0, 0, 0, 1, 0, 10'h3FF, 1, "R9 base1 end");
    drv(20'h0, 0, 0, 0, 20'hC63FF, 1, 1, S_NONE, 0, 0, 0, 0, 0, 10'h000, 1, "R9 base1 miss");
    // R10
    drv(20'h28010, 1, 0, 0, 20'hC6123, 1, 0, S_COM, 19'h010, 0, 0, 0, 1, 10'h123, 1, "R10 host waits");
    drv(20'h00000, 1, 0, 0, 20'hC6123, 1, 0, S_ROM, 19'h0, 0, 0, 1, 0, 10'h123, 1, "R10 host granted next");
    // R11 reset mid-run
    @(negedge clk);
    loc_rd = 0; loc_wr = 0; host_req = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    lr(20'h10004, S_REG, 19'd2, 1, 8'h00, 0, "R11 reg cleared by reset");
    lr(20'hF8000, S_ROM, 19'h08000, 0, 8'h0, 0, "R11 remap cleared");
    drv(20'h0, 0, 0, 0, 20'h0, 0, 0, S_NONE, 0, 0, 0, 0, 0, 0, 0, "R12 no access");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule